// File: doc/BRIEF.md
# Buffered Timer Compare Channel

This block is a single compare channel that sits beside a 16-bit timer/counter and is programmed over an 8-bit CPU register bus. It holds a compare word and checks it against the running count on every timer tick. On a match it raises a sticky flag and drives a waveform bit. The bit can be held, toggled, cleared or set, as chosen by a two-bit action field.

The compare word is loaded in two byte writes. The upper byte is parked in a shared staging byte, and the lower-byte write moves the whole word in one clock. When buffering is enabled, CPU writes land in a shadow word. The shadow word reaches the active compare word only on an external update strobe, which the counter logic raises at the safe point of its sequence. When buffering is off, writes go straight to the active word. Two further features help software: a force strobe applies the match action without touching the flag, and a write to the counter masks the match on the next timer tick.

Top module: `cmp_chan`

## Requirements
- R1: After reset, wave_out is 0, cmp_flag is 0, the action field is 00 and cmp_active equals the reset compare parameter, which defaults to 0.
- R2: With dbuf_en low, a write to select 1 (upper byte) only loads the staging byte and leaves cmp_active unchanged. A following write to select 0 (lower byte) sets cmp_active to {staging byte, written byte} on the next clock.
- R3: With dbuf_en high, the two-byte write loads the shadow word and leaves cmp_active unchanged. A clock with both upd_stb and dbuf_en high copies the shadow word into cmp_active.
- R4: upd_stb has no effect on cmp_active while dbuf_en is low.
- R5: bus_rdata at select 0 and select 1 returns the low and high byte of the shadow word when dbuf_en is high, and of cmp_active otherwise. The read never goes through the staging byte.
- R6: A match occurs on a clock where tick is high, cnt_val equals cmp_active and the match is not masked. On the next clock the match sets cmp_flag and applies the action to wave_out.
- R7: The action field is written at select 2, bits [1:0]. Its encodings are: 00 holds wave_out, 01 toggles it, 10 clears it, 11 sets it.
- R8: cmp_flag stays set until a write at select 3 with bit 0 = 1. A write with bit 0 = 0 leaves the flag alone. A match in the same clock as the clearing write wins, and the flag stays set.
- R9: A write at select 2 with bit 2 = 1 while pwm_mode is low applies the action to wave_out as a match would, but does not set cmp_flag. While pwm_mode is high the force bit is ignored.
- R10: cnt_wr masks any match in its own clock and on the first tick after it, even when ticks are absent for several clocks in between.
- R11: A new action field applies to an event in the same clock in which it is written. wave_out keeps its value when pwm_mode changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_val | input | CNT_W | Running counter value |
| tick | input | 1 | Timer clock enable |
| cnt_wr | input | 1 | CPU wrote the counter this clock |
| pwm_mode | input | 1 | 1 = PWM waveform mode (force ignored) |
| dbuf_en | input | 1 | 1 = compare writes go to the shadow word |
| upd_stb | input | 1 | Shadow-to-active transfer strobe |
| bus_wr | input | 1 | Register write enable |
| bus_sel | input | 2 | Register select: 0 low byte, 1 high byte, 2 control, 3 flag |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data for bus_sel |
| cmp_active | output | CNT_W | Active compare word |
| cmp_flag | output | 1 | Sticky compare flag |
| wave_out | output | 1 | Waveform output bit |

## Verification
The bench builds the channel with its default widths: a 16-bit compare word on an 8-bit bus, with the shadow-word variant generated in. With these values, the byte-staging path, the shadow transfer and the read-back choice between shadow and active word can all be exercised. Directed sequences cover each action code, flag clearing and the force and masking corners. A long random stretch then places the counter on the reference model's compare word about half the time, so that matches collide with writes, strobes and counter loads.

// File: rtl/cmp_chan_pkg.sv
package cmp_chan_pkg;

   // Register selects on the CPU side
   localparam logic [1:0] SEL_LO  = 2'd0;
   localparam logic [1:0] SEL_HI  = 2'd1;
   localparam logic [1:0] SEL_CTL = 2'd2;
   localparam logic [1:0] SEL_FLG = 2'd3;

   // Control byte layout
   localparam int CTL_FORCE_BIT = 2;
   localparam int FLG_CLR_BIT   = 0;

   typedef enum logic [1:0] {
      ACT_HOLD   = 2'b00,
      ACT_TOGGLE = 2'b01,
      ACT_CLEAR  = 2'b10,
      ACT_SET    = 2'b11
   } act_e;

endpackage

// File: rtl/cmp_chan_regs.sv
module cmp_chan_regs
   import cmp_chan_pkg::*;
#(
   parameter int              BUS_W        = 8,
   parameter int              CNT_W        = 16,
   parameter bit              DBUF_SUPPORT = 1'b1,
   parameter logic [CNT_W-1:0] RST_CMP     = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic [1:0]       bus_sel,
   input  logic [BUS_W-1:0] bus_wdata,
   input  logic             dbuf_en,
   input  logic             upd_stb,
   output logic [CNT_W-1:0] cmp_act,
   output logic [CNT_W-1:0] cmp_vis
);

   localparam int HI_W = CNT_W - BUS_W;

   logic             wr_hi;
   logic             wr_lo;
   logic [HI_W-1:0]  stage_q;
   logic [CNT_W-1:0] word_in;
   logic [CNT_W-1:0] act_q;

   assign wr_hi   = bus_wr && (bus_sel == SEL_HI);
   assign wr_lo   = bus_wr && (bus_sel == SEL_LO);
   assign word_in = {stage_q, bus_wdata};

   // Staging byte for the upper half of the word
   always_ff @(posedge clk) begin
      if (!rst_n)      stage_q <= '0;
      else if (wr_hi)  stage_q <= bus_wdata[HI_W-1:0];
   end

   generate
      if (DBUF_SUPPORT) begin : g_shadow
         logic [CNT_W-1:0] shd_q;

         always_ff @(posedge clk) begin
            if (!rst_n)                 shd_q <= RST_CMP;
            else if (wr_lo && dbuf_en)  shd_q <= word_in;
         end

         always_ff @(posedge clk) begin
            if (!rst_n)                  act_q <= RST_CMP;
            else if (upd_stb && dbuf_en) act_q <= shd_q;
            else if (wr_lo && !dbuf_en)  act_q <= word_in;
         end

         assign cmp_vis = dbuf_en ? shd_q : act_q;
      end else begin : g_direct
         logic unused_ctl;
         assign unused_ctl = ^{dbuf_en, upd_stb};

         always_ff @(posedge clk) begin
            if (!rst_n)      act_q <= RST_CMP;
            else if (wr_lo)  act_q <= word_in;
         end

         assign cmp_vis = act_q;
      end
   endgenerate

   assign cmp_act = act_q;

endmodule

// File: rtl/cmp_chan_match.sv
module cmp_chan_match #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             cnt_wr,
   input  logic [CNT_W-1:0] cnt_val,
   input  logic [CNT_W-1:0] cmp_act,
   output logic             hit
);

   // Pending mask: armed by a counter write, consumed by the next tick
   logic mask_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      mask_q <= 1'b0;
      else if (cnt_wr) mask_q <= 1'b1;
      else if (tick)   mask_q <= 1'b0;
   end

   assign hit = tick && !cnt_wr && !mask_q && (cnt_val == cmp_act);

endmodule

// File: rtl/cmp_chan_ctl.sv
module cmp_chan_ctl
   import cmp_chan_pkg::*;
#(
   parameter int BUS_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic [1:0]       bus_sel,
   input  logic [BUS_W-1:0] bus_wdata,
   input  logic             pwm_mode,
   input  logic             hit,
   output act_e             act_mode,
   output logic             flag,
   output logic             wave
);

   logic ctl_wr;
   logic flg_clr;
   logic force_ev;
   logic event_any;
   act_e eff_mode;
   act_e mode_q;
   logic wave_q;
   logic wave_d;
   logic flag_q;

   assign ctl_wr    = bus_wr && (bus_sel == SEL_CTL);
   assign flg_clr   = bus_wr && (bus_sel == SEL_FLG) && bus_wdata[FLG_CLR_BIT];
   assign eff_mode  = ctl_wr ? act_e'(bus_wdata[1:0]) : mode_q;
   assign force_ev  = ctl_wr && bus_wdata[CTL_FORCE_BIT] && !pwm_mode;
   assign event_any = hit || force_ev;

   always_comb begin
      wave_d = wave_q;
      if (event_any) begin
         case (eff_mode)
            ACT_TOGGLE: wave_d = !wave_q;
            ACT_CLEAR:  wave_d = 1'b0;
            ACT_SET:    wave_d = 1'b1;
            default:    wave_d = wave_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= ACT_HOLD;
         wave_q <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         if (ctl_wr) mode_q <= eff_mode;
         wave_q <= wave_d;
         if (hit)          flag_q <= 1'b1;
         else if (flg_clr) flag_q <= 1'b0;
      end
   end

   assign act_mode = mode_q;
   assign flag     = flag_q;
   assign wave     = wave_q;

endmodule

// File: rtl/cmp_chan.sv
module cmp_chan
   import cmp_chan_pkg::*;
#(
   parameter int               BUS_W        = 8,
   parameter int               CNT_W        = 16,
   parameter bit               DBUF_SUPPORT = 1'b1,
   parameter logic [CNT_W-1:0] RST_CMP      = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt_val,
   input  logic             tick,
   input  logic             cnt_wr,
   input  logic             pwm_mode,
   input  logic             dbuf_en,
   input  logic             upd_stb,
   input  logic             bus_wr,
   input  logic [1:0]       bus_sel,
   input  logic [BUS_W-1:0] bus_wdata,
   output logic [BUS_W-1:0] bus_rdata,
   output logic [CNT_W-1:0] cmp_active,
   output logic             cmp_flag,
   output logic             wave_out
);

   generate
      if (CNT_W != 2 * BUS_W) begin : g_bad_width
         $error("cmp_chan: CNT_W must be twice BUS_W");
      end
      if (BUS_W < 3) begin : g_bad_bus
         $error("cmp_chan: BUS_W must hold the control bits");
      end
   endgenerate

   logic [CNT_W-1:0] vis_w;
   logic             hit_w;
   act_e             mode_w;

   cmp_chan_regs #(
      .BUS_W(BUS_W), .CNT_W(CNT_W),
      .DBUF_SUPPORT(DBUF_SUPPORT), .RST_CMP(RST_CMP)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_wr(bus_wr), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
      .dbuf_en(dbuf_en), .upd_stb(upd_stb),
      .cmp_act(cmp_active), .cmp_vis(vis_w)
   );

   cmp_chan_match #(.CNT_W(CNT_W)) u_match (
      .clk(clk), .rst_n(rst_n),
      .tick(tick), .cnt_wr(cnt_wr),
      .cnt_val(cnt_val), .cmp_act(cmp_active),
      .hit(hit_w)
   );

   cmp_chan_ctl #(.BUS_W(BUS_W)) u_ctl (
      .clk(clk), .rst_n(rst_n),
      .bus_wr(bus_wr), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
      .pwm_mode(pwm_mode), .hit(hit_w),
      .act_mode(mode_w), .flag(cmp_flag), .wave(wave_out)
   );

   always_comb begin
      bus_rdata = '0;
      case (bus_sel)
         SEL_LO:  bus_rdata = vis_w[BUS_W-1:0];
         SEL_HI:  bus_rdata = vis_w[CNT_W-1:BUS_W];
         SEL_CTL: bus_rdata[1:0] = mode_w;
         default: bus_rdata[FLG_CLR_BIT] = cmp_flag;
      endcase
   end

endmodule

// File: rtl/cmp_chan_chk.sv
module cmp_chan_chk
   import cmp_chan_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic             cnt_wr,
   input logic             dbuf_en,
   input logic             upd_stb,
   input logic             bus_wr,
   input logic [1:0]       bus_sel,
   input logic             bus_wdata0,
   input logic [CNT_W-1:0] cmp_active,
   input logic             cmp_flag,
   input logic             wave_out
);

   // R2: an upper-byte write alone never moves the active word
   p_hi_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_sel == SEL_HI && !(dbuf_en && upd_stb)) |=> $stable(cmp_active));

   // R3: while buffering, only the update strobe changes the active word
   p_shadow_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (dbuf_en && !upd_stb) |=> $stable(cmp_active));

   // R4: without buffering the strobe is inert; only a low-byte write counts
   p_no_upd_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!dbuf_en && !(bus_wr && bus_sel == SEL_LO)) |=> $stable(cmp_active));

   // R8: the flag is sticky until a clearing write
   p_flag_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_flag && !(bus_wr && bus_sel == SEL_FLG && bus_wdata0)) |=> cmp_flag);

   // R9: the flag can only rise from a tick, so a force never sets it
   p_force_noflag_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> !$rose(cmp_flag));

   // R10: a counter write masks the match in its own clock
   p_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> !$rose(cmp_flag));

   // R11: without tick or control write the waveform holds, whatever the mode flag
   p_wave_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !(bus_wr && bus_sel == SEL_CTL)) |=> $stable(wave_out));

endmodule

bind cmp_chan cmp_chan_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_wr(cnt_wr),
   .dbuf_en(dbuf_en), .upd_stb(upd_stb),
   .bus_wr(bus_wr), .bus_sel(bus_sel), .bus_wdata0(bus_wdata[0]),
   .cmp_active(cmp_active), .cmp_flag(cmp_flag), .wave_out(wave_out)
);

// File: tb/cmp_chan_test.sv
`timescale 1ns/1ps
module cmp_chan_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cnt_val = '0;
   logic        tick = 0, cnt_wr = 0, pwm_mode = 0, dbuf_en = 0, upd_stb = 0;
   logic        bus_wr = 0;
   logic [1:0]  bus_sel = 0;
   logic [7:0]  bus_wdata = 0;
   logic [7:0]  bus_rdata;
   logic [15:0] cmp_active;
   logic        cmp_flag, wave_out;

   int checks = 0;
   int fails = 0;
   string cur_req = "R1";

   // Reference model state
   int m_stage = 0, m_shd = 0, m_act = 0, m_mode = 0;
   bit m_flag = 0, m_wave = 0, m_mask = 0;

   always #4 clk = ~clk;

   cmp_chan uut (
      .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .tick(tick), .cnt_wr(cnt_wr),
      .pwm_mode(pwm_mode), .dbuf_en(dbuf_en), .upd_stb(upd_stb),
      .bus_wr(bus_wr), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .cmp_active(cmp_active),
      .cmp_flag(cmp_flag), .wave_out(wave_out)
   );

   task automatic chk(input string req, input int got, input int exp);
      checks++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   function automatic int model_rd();
      int vis = dbuf_en ? m_shd : m_act;
      case (bus_sel)
         2'd0: return vis & 8'hFF;
         2'd1: return (vis >> 8) & 8'hFF;
         2'd2: return m_mode;
         default: return int'(m_flag);
      endcase
   endfunction

   task automatic model_step();
      bit hit, ctl, frc, ev;
      int emode, old_shd;
      hit = tick && !cnt_wr && !m_mask && (int'(cnt_val) == m_act);
      ctl = bus_wr && bus_sel == 2'd2;
      emode = ctl ? int'(bus_wdata[1:0]) : m_mode;
      frc = ctl && bus_wdata[2] && !pwm_mode;
      ev = hit || frc;
      if (ev) begin
         if (emode == 1) m_wave = !m_wave;
         else if (emode == 2) m_wave = 0;
         else if (emode == 3) m_wave = 1;
      end
      if (hit) m_flag = 1;
      else if (bus_wr && bus_sel == 2'd3 && bus_wdata[0]) m_flag = 0;
      if (ctl) m_mode = emode;
      old_shd = m_shd;
      if (dbuf_en && upd_stb) m_act = old_shd;
      if (bus_wr && bus_sel == 2'd0) begin
         if (dbuf_en) m_shd = (m_stage << 8) | int'(bus_wdata);
         else         m_act = (m_stage << 8) | int'(bus_wdata);
      end
      if (bus_wr && bus_sel == 2'd1) m_stage = int'(bus_wdata);
      if (cnt_wr) m_mask = 1;
      else if (tick) m_mask = 0;
   endtask

   task automatic cyc();
      @(posedge clk);
      model_step();
      @(negedge clk);
      chk({cur_req, " model wave"}, int'(wave_out), int'(m_wave));
      chk({cur_req, " model flag"}, int'(cmp_flag), int'(m_flag));
      chk({cur_req, " model active"}, int'(cmp_active), m_act);
      chk({cur_req, " model rdata"}, int'(bus_rdata), model_rd());
   endtask

   task automatic wr(input logic [1:0] s, input logic [7:0] d);
      bus_wr = 1; bus_sel = s; bus_wdata = d;
      cyc();
      bus_wr = 0;
   endtask

   task automatic tk(input logic [15:0] c);
      cnt_val = c; tick = 1;
      cyc();
      tick = 0;
   endtask

   task automatic rd(input string req, input logic [1:0] s, input int exp);
      bus_sel = s;
      #1;
      chk(req, int'(bus_rdata), exp);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL R1 watchdog: got timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      #1;
      cur_req = "R1";
      chk("R1 wave", int'(wave_out), 0);
      chk("R1 flag", int'(cmp_flag), 0);
      chk("R1 active", int'(cmp_active), 0);
      rd("R1 mode", 2'd2, 0);

      cur_req = "R2";
      wr(2'd1, 8'h12);
      chk("R2 hi only", int'(cmp_active), 0);
      wr(2'd0, 8'h34);
      chk("R2 word", int'(cmp_active), 16'h1234);

      cur_req = "R5";
      rd("R5 hi", 2'd1, 8'h12);
      rd("R5 lo", 2'd0, 8'h34);
      wr(2'd1, 8'h56);
      rd("R5 no staging", 2'd1, 8'h12);

      cur_req = "R3";
      dbuf_en = 1;
      wr(2'd1, 8'hAB);
      wr(2'd0, 8'hCD);
      chk("R3 held", int'(cmp_active), 16'h1234);
      rd("R3 shadow lo", 2'd0, 8'hCD);
      rd("R3 shadow hi", 2'd1, 8'hAB);
      upd_stb = 1; cyc(); upd_stb = 0;
      chk("R3 transfer", int'(cmp_active), 16'hABCD);

      cur_req = "R4";
      wr(2'd1, 8'h11);
      wr(2'd0, 8'h11);
      dbuf_en = 0;
      upd_stb = 1; cyc(); upd_stb = 0;
      chk("R4 inert", int'(cmp_active), 16'hABCD);
      rd("R4 read active", 2'd1, 8'hAB);

      cur_req = "R7";
      wr(2'd2, 8'h01);
      tk(16'hABCD);
      chk("R6 toggle", int'(wave_out), 1);
      chk("R6 flag", int'(cmp_flag), 1);
      tk(16'hABCC);
      chk("R6 mismatch", int'(wave_out), 1);
      wr(2'd2, 8'h02); tk(16'hABCD);
      chk("R7 clear", int'(wave_out), 0);
      wr(2'd2, 8'h03); tk(16'hABCD);
      chk("R7 set", int'(wave_out), 1);
      wr(2'd2, 8'h00); tk(16'hABCD);
      chk("R7 hold", int'(wave_out), 1);

      cur_req = "R8";
      wr(2'd3, 8'h00);
      chk("R8 zero keeps", int'(cmp_flag), 1);
      wr(2'd3, 8'h01);
      chk("R8 clear", int'(cmp_flag), 0);
      cnt_val = 16'hABCD; tick = 1;
      wr(2'd3, 8'h01);
      tick = 0;
      chk("R8 set wins", int'(cmp_flag), 1);
      wr(2'd3, 8'h01);

      cur_req = "R9";
      wr(2'd2, 8'h05);
      chk("R9 force", int'(wave_out), 0);
      chk("R9 no flag", int'(cmp_flag), 0);
      pwm_mode = 1;
      wr(2'd2, 8'h05);
      chk("R9 pwm ignore", int'(wave_out), 0);
      pwm_mode = 0;

      cur_req = "R10";
      cnt_wr = 1; cyc(); cnt_wr = 0;
      tk(16'hABCD);
      chk("R10 masked", int'(wave_out), 0);
      chk("R10 masked flag", int'(cmp_flag), 0);
      tk(16'hABCD);
      chk("R10 unmasked", int'(wave_out), 1);
      wr(2'd3, 8'h01);
      cnt_wr = 1; cyc(); cnt_wr = 0;
      repeat (3) cyc();
      tk(16'hABCD);
      chk("R10 masked stopped", int'(wave_out), 1);
      cnt_wr = 1; tk(16'hABCD); cnt_wr = 0;
      chk("R10 same clock", int'(wave_out), 1);
      tk(16'hABCD);
      chk("R10 next tick", int'(wave_out), 1);
      tk(16'hABCD);
      chk("R10 released", int'(wave_out), 0);

      cur_req = "R11";
      wr(2'd2, 8'h06);
      chk("R11 immediate", int'(wave_out), 0);
      wr(2'd2, 8'h07);
      chk("R11 set", int'(wave_out), 1);
      pwm_mode = 1; cyc(); cyc(); pwm_mode = 0; cyc();
      chk("R11 pwm keep", int'(wave_out), 1);

      cur_req = "R6";
      for (int i = 0; i < 3000; i++) begin
         bus_wr    = ($urandom_range(3) == 0);
         bus_sel   = 2'($urandom_range(3));
         bus_wdata = 8'($urandom);
         cnt_val   = ($urandom_range(1) == 0) ? 16'(m_act) : 16'($urandom);
         tick      = ($urandom_range(1) == 0);
         cnt_wr    = ($urandom_range(7) == 0);
         upd_stb   = ($urandom_range(7) == 0);
         if ($urandom_range(15) == 0) dbuf_en = !dbuf_en;
         if ($urandom_range(15) == 0) pwm_mode = !pwm_mode;
         cyc();
      end
      bus_wr = 0; tick = 0; cnt_wr = 0; upd_stb = 0;
      cyc();

      summary();
      $finish;
   end

endmodule